// File: doc/BRIEF.md
# Radix-4 / Radix-8 FFT Butterfly with Inverse Mode

This block is the arithmetic core of one stage of a multipath delay commutator FFT pipeline. It accepts eight complex samples in parallel on every clock and returns eight complex results two clocks later. In radix-4 mode the eight lanes form two unrelated four-point groups. Each group is transformed on its own. In radix-8 mode all eight lanes form one eight-point DFT, which is the configuration used for a final stage. Twiddle rotation between stages and reordering of data are handled elsewhere.

A per-sample inverse flag reuses the forward datapath. The real and imaginary parts are exchanged on entry and on exit. This is equivalent to conjugating both sides and multiplying by j, but it avoids negating the most negative code. The inverse result is scaled by 1/N (N = 4 or 8) through a rounded arithmetic right shift. The multiplications by -j inside the butterfly are wire swaps with a sign change. The two diagonal eighth-root factors use a rounded fixed-point constant for 1/sqrt(2).

Top module: `fft_bfly48`

## Requirements
- R1: With `radix8`=0, output lanes 0..3 are the forward four-point DFT of input lanes 0..3, with output lane k holding bin k. Output lanes 4..7 are the same transform of input lanes 4..7. The two groups do not affect each other.
- R2: With `radix8`=1, output lane k (0..7) holds bin k of the forward eight-point DFT of input lanes 0..7, X[k] = sum of x[n]·exp(-j2πnk/8).
- R3: With `inverse`=1, each output is sum of x[n]·exp(+j2πnk/N), divided by N. N is 4 in radix-4 mode and 8 in radix-8 mode. The division is an arithmetic right shift with round-half-up.
- R4: With `inverse`=0, no scaling is applied. Any component outside the signed W-bit range is clamped to -2^(W-1) or 2^(W-1)-1.
- R5: `out_valid` is high exactly two clocks after the cycle in which `in_valid` was high. The outputs carry the result of that input during that cycle.
- R6: Every output component is within 1 LSB of the exact (clamped) value.
- R7: After reset, `out_valid` is low until a valid input has passed through the pipeline.
- R8: The mode and inverse flags are taken per sample, so inputs on consecutive cycles with different settings each get their own transform.
- R9: In inverse mode, full-scale negative inputs (-2^(W-1) on every component) give exact results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample group is valid |
| radix8 | input | 1 | 1: one eight-point DFT, 0: two four-point DFTs |
| inverse | input | 1 | 1: inverse transform with 1/N scaling |
| in_re | input | 8*W | Real parts, lane i at bits [i*W +: W], signed |
| in_im | input | 8*W | Imaginary parts, same packing |
| out_valid | output | 1 | Output group is valid |
| out_re | output | 8*W | Real parts of results, lane k is bin k of its group |
| out_im | output | 8*W | Imaginary parts of results |

## Verification
The assertions check on every cycle that valid emerges two clocks after it enters. They also check that a constant group in radix-4 mode leaves bins 1..3 at exactly zero, and that a zero upper group gives zero upper outputs whatever the lower lanes hold. A constant input to the inverse eight-point transform must return exactly that constant in bin 0 and zero in every other bin. Numeric accuracy against a floating-point DFT, clamping of forward results, full-scale negative inputs, reset state and back-to-back changes of mode can only be shown by the bench's scenarios. Those scenarios compare every lane against a reference computed with trigonometric sums.

// File: rtl/fft_bfly48.sv
module fft_bfly48 #(
  parameter int W  = 16,
  parameter int CF = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           radix8,
  input  logic           inverse,
  input  logic [8*W-1:0] in_re,
  input  logic [8*W-1:0] in_im,
  output logic           out_valid,
  output logic [8*W-1:0] out_re,
  output logic [8*W-1:0] out_im
);
  localparam int G = W + 2;
  localparam int S = W + 4;
  localparam int P = S + CF + 2;
  localparam longint KC = longint'(0.7071067811865476 * (2.0 ** CF));
  localparam logic signed [P-1:0] KW = P'(KC);
  localparam logic signed [S:0] MX = (S+1)'((1 << (W-1)) - 1);
  localparam logic signed [S:0] MN = ~MX;

  function automatic logic signed [S-1:0] mulc(input logic signed [S-1:0] v);
    logic signed [P-1:0] p;
    p = v * KW;
    p = p + (signed'(P'(1)) <<< (CF-1));
    return S'(p >>> CF);
  endfunction

  function automatic logic signed [W-1:0] fin(input logic signed [S-1:0] v, input int sh);
    logic signed [S:0] r;
    r = (S+1)'(v);
    if (sh > 0) begin
      r = r + (signed'((S+1)'(1)) <<< (sh-1));
      r = r >>> sh;
    end
    if (r > MX) return MX[W-1:0];
    if (r < MN) return MN[W-1:0];
    return r[W-1:0];
  endfunction

  logic signed [W-1:0] xr [8];
  logic signed [W-1:0] xi [8];
  logic signed [G-1:0] fr [2][4];
  logic signed [G-1:0] fi [2][4];
  logic signed [G-1:0] qr [2][4];
  logic signed [G-1:0] qi [2][4];
  logic                v1, r8_q, inv_q;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      xr[i] = inverse ? in_im[i*W +: W] : in_re[i*W +: W];
      xi[i] = inverse ? in_re[i*W +: W] : in_im[i*W +: W];
    end
    for (int g = 0; g < 2; g++) begin
      logic signed [G-1:0] er [4];
      logic signed [G-1:0] ei [4];
      logic signed [G-1:0] s02r, s02i, d02r, d02i, s13r, s13i, d13r, d13i;
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx   = radix8 ? 2*k + g : 4*g + k;
        er[k] = G'(xr[idx]);
        ei[k] = G'(xi[idx]);
      end
      s02r = er[0] + er[2];  s02i = ei[0] + ei[2];
      d02r = er[0] - er[2];  d02i = ei[0] - ei[2];
      s13r = er[1] + er[3];  s13i = ei[1] + ei[3];
      d13r = er[1] - er[3];  d13i = ei[1] - ei[3];
      fr[g][0] = s02r + s13r;  fi[g][0] = s02i + s13i;
      fr[g][1] = d02r + d13i;  fi[g][1] = d02i - d13r;
      fr[g][2] = s02r - s13r;  fi[g][2] = s02i - s13i;
      fr[g][3] = d02r - d13i;  fi[g][3] = d02i + d13r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; r8_q <= 1'b0; inv_q <= 1'b0;
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 4; k++) begin
          qr[g][k] <= '0; qi[g][k] <= '0;
        end
    end else begin
      v1 <= in_valid; r8_q <= radix8; inv_q <= inverse;
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 4; k++) begin
          qr[g][k] <= fr[g][k]; qi[g][k] <= fi[g][k];
        end
    end
  end

  logic signed [S-1:0] yr [8];
  logic signed [S-1:0] yi [8];
  int sh;

  always_comb begin
    sh = inv_q ? (r8_q ? 3 : 2) : 0;
    for (int k = 0; k < 4; k++) begin
      logic signed [S-1:0] ar, ai, br, bi, tr, ti;
      ar = S'(qr[0][k]); ai = S'(qi[0][k]);
      br = S'(qr[1][k]); bi = S'(qi[1][k]);
      case (k)
        1:       begin tr = mulc(br + bi); ti = mulc(bi - br); end
        2:       begin tr = bi;            ti = -br;           end
        3:       begin tr = mulc(bi - br); ti = mulc(-br - bi); end
        default: begin tr = br;            ti = bi;            end
      endcase
      if (r8_q) begin
        yr[k] = ar + tr;  yi[k] = ai + ti;
        yr[k+4] = ar - tr; yi[k+4] = ai - ti;
      end else begin
        yr[k] = ar;  yi[k] = ai;
        yr[k+4] = br; yi[k+4] = bi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re <= '0;
      out_im <= '0;
    end else begin
      out_valid <= v1;
      for (int k = 0; k < 8; k++) begin
        out_re[k*W +: W] <= inv_q ? fin(yi[k], sh) : fin(yr[k], sh);
        out_im[k*W +: W] <= inv_q ? fin(yr[k], sh) : fin(yi[k], sh);
      end
    end
  end
endmodule

// File: rtl/fft_bfly48_chk.sv
module fft_bfly48_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           radix8,
  input logic           inverse,
  input logic [8*W-1:0] in_re,
  input logic [8*W-1:0] in_im,
  input logic           out_valid,
  input logic [8*W-1:0] out_re,
  input logic [8*W-1:0] out_im
);
  logic lo_same, all_same, hi_zero;

  always_comb begin
    lo_same  = 1'b1;
    all_same = 1'b1;
    for (int i = 1; i < 8; i++) begin
      if (in_re[i*W +: W] != in_re[W-1:0] || in_im[i*W +: W] != in_im[W-1:0]) begin
        all_same = 1'b0;
        if (i < 4) lo_same = 1'b0;
      end
    end
    hi_zero = (in_re[8*W-1:4*W] == '0) && (in_im[8*W-1:4*W] == '0);
  end

  p_latency_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_latency_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  p_const_bins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !radix8 && !inverse && lo_same) |-> ##2
      (out_re[4*W-1:W] == '0 && out_im[4*W-1:W] == '0));

  p_groups_apart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !radix8 && hi_zero) |-> ##2
      (out_re[8*W-1:4*W] == '0 && out_im[8*W-1:4*W] == '0));

  p_inv_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && radix8 && inverse && all_same) |-> ##2
      (out_re[W-1:0] == $past(in_re[W-1:0], 2) && out_im[W-1:0] == $past(in_im[W-1:0], 2)
       && out_re[8*W-1:W] == '0 && out_im[8*W-1:W] == '0));
endmodule

bind fft_bfly48 fft_bfly48_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .radix8(radix8), .inverse(inverse),
  .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/fft_bfly48_bench.sv
module fft_bfly48_bench;
  localparam int W = 16;
  localparam real PI = 3.14159265358979323846;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           radix8 = 1'b0;
  logic           inverse = 1'b0;
  logic [8*W-1:0] in_re = '0;
  logic [8*W-1:0] in_im = '0;
  logic           out_valid;
  logic [8*W-1:0] out_re;
  logic [8*W-1:0] out_im;

  fft_bfly48 #(.W(W)) u_fft_bfly48 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .radix8(radix8), .inverse(inverse),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    finished = 1'b0;
  real   q_re[$];
  real   q_im[$];
  int    q_cyc[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real clampr(input real v);
    real mx = 2.0 ** (W-1) - 1.0;
    real mn = -(2.0 ** (W-1));
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic drive(input logic r8, input logic inv, input int vr[8], input int vi[8],
                       input string tag);
    int  n_pts;
    real s;
    n_pts = r8 ? 8 : 4;
    s = inv ? 1.0 : -1.0;
    @(negedge clk);
    for (int o = 0; o < 8; o++) begin
      int  base;
      int  k;
      real accr;
      real acci;
      base = r8 ? 0 : (o / 4) * 4;
      k = r8 ? o : o % 4;
      accr = 0.0;
      acci = 0.0;
      for (int n = 0; n < n_pts; n++) begin
        real th;
        real c;
        real sn;
        th = s * 2.0 * PI * n * k / n_pts;
        c = $cos(th);
        sn = $sin(th);
        accr += vr[base+n] * c - vi[base+n] * sn;
        acci += vr[base+n] * sn + vi[base+n] * c;
      end
      if (inv) begin
        accr = accr / n_pts;
        acci = acci / n_pts;
      end
      q_re.push_back(clampr(accr));
      q_im.push_back(clampr(acci));
    end
    q_cyc.push_back(cyc + 2);
    q_tag.push_back(tag);
    in_valid = 1'b1;
    radix8 = r8;
    inverse = inv;
    for (int i = 0; i < 8; i++) begin
      in_re[i*W +: W] = vr[i][W-1:0];
      in_im[i*W +: W] = vi[i][W-1:0];
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_re = '0;
    in_im = '0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_chk++;
      if (q_tag.size() == 0) begin
        n_bad++;
        $display("FAIL R5: out_valid with no pending input, actual=1 expected=0");
      end else begin
        string tag;
        int    ec;
        bit    bad;
        tag = q_tag.pop_front();
        ec = q_cyc.pop_front();
        bad = 1'b0;
        if (ec != cyc) begin
          bad = 1'b1;
          $display("FAIL R5 (%s): result cycle actual=%0d expected=%0d", tag, cyc, ec);
        end
        for (int l = 0; l < 8; l++) begin
          real er;
          real ei;
          real ar;
          real ai;
          er = q_re.pop_front();
          ei = q_im.pop_front();
          ar = $itor($signed(out_re[l*W +: W]));
          ai = $itor($signed(out_im[l*W +: W]));
          if (absr(ar - er) > 1.0001 || absr(ai - ei) > 1.0001) begin
            bad = 1'b1;
            $display("FAIL R6 (%s) lane %0d: actual=(%0.1f,%0.1f) expected=(%0.3f,%0.3f)",
                     tag, l, ar, ai, er, ei);
          end
        end
        if (bad) n_bad++;
      end
    end
  end

  task automatic rnd_vec(output int v[8], input int amp);
    for (int i = 0; i < 8; i++) v[i] = $urandom_range(0, 2*amp) - amp;
  endtask

  initial begin
    int ar[8];
    int ai[8];
    int zr[8];
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R7: out_valid in reset actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R7: out_valid after reset actual=%b expected=0", out_valid);
    end

    for (int i = 0; i < 8; i++) begin zr[i] = 0; ar[i] = 0; ai[i] = 0; end
    ar[0] = 1000; ai[0] = -300;
    drive(1'b0, 1'b0, ar, ai, "R1 impulse");
    idle(3);

    rnd_vec(ar, 4000); rnd_vec(ai, 4000);
    drive(1'b0, 1'b0, ar, ai, "R1 random");
    idle(2);

    for (int i = 0; i < 8; i++) begin ar[i] = 0; ai[i] = 0; end
    ar[1] = 2000; ai[1] = 500;
    drive(1'b1, 1'b0, ar, ai, "R2 impulse lane1");
    idle(2);

    for (int t = 0; t < 4; t++) begin
      rnd_vec(ar, 3000); rnd_vec(ai, 3000);
      drive(1'b1, 1'b0, ar, ai, "R2 R6 random");
    end
    idle(2);

    rnd_vec(ar, 30000); rnd_vec(ai, 30000);
    drive(1'b0, 1'b1, ar, ai, "R3 inverse r4");
    rnd_vec(ar, 30000); rnd_vec(ai, 30000);
    drive(1'b1, 1'b1, ar, ai, "R3 inverse r8");
    idle(2);

    for (int i = 0; i < 8; i++) begin ar[i] = 32767; ai[i] = -20000; end
    drive(1'b1, 1'b0, ar, ai, "R4 clamp r8");
    for (int i = 0; i < 8; i++) begin ar[i] = -32768; ai[i] = 25000; end
    drive(1'b0, 1'b0, ar, ai, "R4 clamp r4");
    idle(2);

    for (int i = 0; i < 8; i++) begin ar[i] = -32768; ai[i] = -32768; end
    drive(1'b1, 1'b1, ar, ai, "R9 full-scale r8");
    drive(1'b0, 1'b1, ar, ai, "R9 full-scale r4");
    idle(2);

    for (int t = 0; t < 8; t++) begin
      rnd_vec(ar, 8000); rnd_vec(ai, 8000);
      drive(t[0], t[1], ar, ai, "R8 mixed back-to-back");
    end
    rnd_vec(ar, 8000);
    drive(1'b0, 1'b0, ar, zr, "R8 R1 real only");
    idle(6);

    n_chk++;
    if (q_tag.size() != 0) begin
      n_bad++;
      $display("FAIL R5: pending results actual=%0d expected=0", q_tag.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R5: watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule